// File: doc/BRIEF.md
# Display Interface Signature Unit

This block produces a 32-bit multiple-input signature over the pixel words that leave a display interface, summed across a window of a programmable number of frames. A control word selects the window length, turns capture on, picks between a one-shot capture and a self-rearming free-running capture, and carries a write-one flag that discards any earlier result. A second, read-only location returns the latched signature. A status bit in the control word reports that a complete window has been captured.

The pixel side takes a valid strobe with a 32-bit pixel word, plus single-cycle frame-start and frame-end strobes. A sequencer with four named states controls capture. IDLE means capture is off. ARM waits for the first frame start. RUN accumulates pixels and counts frame ends. HOLD keeps a one-shot result. The transitions are: *enable* (any control write with the enable bit set, from any state, to ARM), *disable* (a control write with enable clear, to IDLE), *open* (ARM to RUN on frame start), *close-rearm* (RUN to ARM at window end when free-run is set), and *close-hold* (RUN to HOLD at window end otherwise).

Software first writes the clear bit alone. It then writes the enable bit together with the frame count and the free-run choice. Writing all zeros turns the block off.

Top module: `display_misr_unit`

## Requirements
- R1: After reset, both the control word and the signature read as zero.
- R2: The control word is at byte offset 0x180 and the signature is at 0x184. Any other address reads zero. Control bits other than 0 to 9 and 31 read zero.
- R3: Control bits [7:0] (frame count), bit 8 (enable) and bit 31 (free-run) read back as last written.
- R4: On each valid pixel in RUN, the accumulator becomes `{acc[30:0], acc[31]^acc[21]^acc[1]^acc[0]} ^ pix_data`. This corresponds to the polynomial x^32+x^22+x^2+x+1.
- R5: Frame ends in RUN are counted. On the frame end that brings the count to the programmed value, the accumulator (including a pixel in that cycle) is copied to the signature, and status bit 9 is set in the same clock.
- R6: A programmed frame count of 0 behaves as 1.
- R7: A control write with bit 10 set clears the status bit and zeroes the signature at that clock edge. Bit 10 is never stored and always reads 0.
- R8: Without free-run, once a window has ended, further frames change neither the signature nor the status until the next control write.
- R9: With free-run, the block rearms at window end. Each following window starts from a zero accumulator at its first frame start and replaces the signature.
- R10: While enable is clear, pixels and frame strobes have no effect: status stays 0 and the signature is unchanged.
- R11: After enable, pixels and frame ends seen before the first frame start are ignored. The accumulator starts from zero at that frame start. Later frame starts inside the window do not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| pix_valid | input | 1 | Pixel word valid |
| pix_data | input | 32 | Pixel word |
| frame_start | input | 1 | First-cycle strobe of a frame |
| frame_end | input | 1 | Last-cycle strobe of a frame |

## Verification
The hardest case to reach from the ports is a window that has closed while stimulus keeps arriving. In one-shot mode the signature must stay frozen. In free-run mode the next window must replace it from a fresh zero start. The stimulus drives extra frames after a one-shot window has completed. It then runs two back-to-back free-running windows built from different pixel seeds, so a design that keeps accumulating or fails to reseed gives a wrong second signature. Stray pixels and a lone frame end are sent before the first frame start to show that arming waits for that strobe.

// File: rtl/misr_pkg.sv
package misr_pkg;
    localparam int SIG_W   = 32;
    localparam int CNT_W   = 8;
    localparam int BIT_EN  = 8;
    localparam int BIT_DONE = 9;
    localparam int BIT_CLR = 10;
    localparam int BIT_FREE = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } win_state_t;

    typedef struct packed {
        logic             free_run;
        logic             enable;
        logic [CNT_W-1:0] frames;
    } misr_cfg_t;

    // one shift of x^32+x^22+x^2+x+1 with the input word folded in
    function automatic logic [SIG_W-1:0] misr_step(input logic [SIG_W-1:0] acc,
                                                   input logic [SIG_W-1:0] word);
        logic fb;
        fb = acc[31] ^ acc[21] ^ acc[1] ^ acc[0];
        return {acc[SIG_W-2:0], fb} ^ word;
    endfunction
endpackage

// File: rtl/misr_regs.sv
module misr_regs
    import misr_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h180,
    parameter logic [ADDR_W-1:0] SIG_OFS  = 12'h184
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SIG_W-1:0]  reg_wdata,
    input  logic              status,
    input  logic [SIG_W-1:0]  signature,
    output misr_cfg_t         cfg,
    output misr_cfg_t         wr_cfg,
    output logic              cfg_wr,
    output logic              clr,
    output logic [SIG_W-1:0]  reg_rdata
);
    logic hit_ctrl;

    always_comb begin
        hit_ctrl        = (reg_addr == CTRL_OFS);
        cfg_wr          = reg_we && hit_ctrl;
        clr             = cfg_wr && reg_wdata[BIT_CLR];
        wr_cfg.frames   = reg_wdata[CNT_W-1:0];
        wr_cfg.enable   = reg_wdata[BIT_EN];
        wr_cfg.free_run = reg_wdata[BIT_FREE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            cfg <= wr_cfg;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl) begin
            reg_rdata[CNT_W-1:0] = cfg.frames;
            reg_rdata[BIT_EN]    = cfg.enable;
            reg_rdata[BIT_DONE]  = status;
            reg_rdata[BIT_FREE]  = cfg.free_run;
        end else if (reg_addr == SIG_OFS) begin
            reg_rdata = signature;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg == $past(wr_cfg))); // R3
endmodule

// File: rtl/misr_accum.sv
module misr_accum
    import misr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_init,
    input  logic             acc_run,
    input  logic             pix_valid,
    input  logic [SIG_W-1:0] pix_data,
    output logic [SIG_W-1:0] acc_nxt
);
    logic [SIG_W-1:0] acc_q;
    logic [SIG_W-1:0] base;

    always_comb begin
        base    = acc_init ? '0 : acc_q;
        acc_nxt = pix_valid ? misr_step(base, pix_data) : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_init || acc_run) begin
            acc_q <= acc_nxt;
        end
    end

    AST_SEED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_init && !pix_valid) |=> (acc_q == '0)); // R11
    AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_init && !acc_run) |=> $stable(acc_q)); // R10
endmodule

// File: rtl/misr_window_fsm.sv
module misr_window_fsm
    import misr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  misr_cfg_t        cfg,
    input  misr_cfg_t        wr_cfg,
    input  logic             cfg_wr,
    input  logic             clr,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [SIG_W-1:0] acc_nxt,
    output logic             acc_init,
    output logic             acc_run,
    output logic [SIG_W-1:0] signature,
    output logic             status
);
    win_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   tgt;
    logic [CNT_W:0]   cnt_inc;
    logic             last;
    logic             win_end;

    always_comb begin
        tgt     = (cfg.frames == '0) ? (CNT_W+1)'(1) : {1'b0, cfg.frames};
        cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
        last    = (cnt_inc == tgt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        acc_init = 1'b0;
        acc_run  = 1'b0;
        win_end  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARM: begin
                if (frame_start) begin
                    acc_init = 1'b1;
                    state_d  = ST_RUN;
                end
            end
            ST_RUN: begin
                acc_run = 1'b1;
                if (frame_end && last) begin
                    win_end = 1'b1;
                    state_d = cfg.free_run ? ST_ARM : ST_HOLD;
                end
            end
            ST_HOLD: ;
            default: state_d = ST_IDLE;
        endcase
        if (cfg_wr) begin
            state_d  = wr_cfg.enable ? ST_ARM : ST_IDLE;
            acc_init = 1'b0;
            acc_run  = 1'b0;
            win_end  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (acc_init) begin
            cnt_q <= '0;
        end else if (acc_run && frame_end) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            signature <= '0;
            status    <= 1'b0;
        end else if (clr) begin
            signature <= '0;
            status    <= 1'b0;
        end else if (win_end) begin
            signature <= acc_nxt;
            status    <= 1'b1;
        end
    end

    AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ({1'b0, cnt_q} < tgt)); // R5
    AST_STATUS_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(state_q == ST_RUN && frame_end)); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!status && signature == '0)); // R7
    AST_OFF_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.enable |-> (state_q == ST_IDLE)); // R10
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cfg_wr) |=> $stable(signature)); // R8
endmodule

// File: rtl/display_misr_unit.sv
module display_misr_unit
    import misr_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h180,
    parameter logic [ADDR_W-1:0] SIG_OFS  = 12'h184
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              pix_valid,
    input  logic [31:0]       pix_data,
    input  logic              frame_start,
    input  logic              frame_end
);
    misr_cfg_t        cfg, wr_cfg;
    logic             cfg_wr, clr;
    logic             status;
    logic [SIG_W-1:0] signature;
    logic [SIG_W-1:0] acc_nxt;
    logic             acc_init, acc_run;

    misr_regs #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .SIG_OFS (SIG_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .status   (status),
        .signature(signature),
        .cfg      (cfg),
        .wr_cfg   (wr_cfg),
        .cfg_wr   (cfg_wr),
        .clr      (clr),
        .reg_rdata(reg_rdata)
    );

    misr_window_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .wr_cfg     (wr_cfg),
        .cfg_wr     (cfg_wr),
        .clr        (clr),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .acc_nxt    (acc_nxt),
        .acc_init   (acc_init),
        .acc_run    (acc_run),
        .signature  (signature),
        .status     (status)
    );

    misr_accum u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_init (acc_init),
        .acc_run  (acc_run),
        .pix_valid(pix_valid),
        .pix_data (pix_data),
        .acc_nxt  (acc_nxt)
    );
endmodule

// File: tb/tb_display_misr_unit.sv
module tb_display_misr_unit;
    localparam logic [11:0] A_CTRL = 12'h180;
    localparam logic [11:0] A_SIG  = 12'h184;

    // {frames[7:0], pixels per frame[7:0], seed[15:0]}
    localparam logic [31:0] VEC [5] = '{
        32'h01_04_1234, 32'h02_03_BEEF, 32'h03_05_0F0F,
        32'h01_01_0001, 32'h04_02_A5A5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [31:0] pix_data = '0;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    display_misr_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
        .pix_data(pix_data), .frame_start(frame_start), .frame_end(frame_end)
    );

    function automatic logic [31:0] model_step(input logic [31:0] a, input logic [31:0] w);
        return {a[30:0], a[31] ^ a[21] ^ a[1] ^ a[0]} ^ w;
    endfunction

    function automatic logic [31:0] pix_word(input int seed, input int f, input int i);
        return ((32'(seed)) << 16) ^ (32'(f) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ 32'(i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic frame(input int npix, input int seed, input int f, inout logic [31:0] acc);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < npix; i++) begin
            pix_valid = 1'b1;
            pix_data  = pix_word(seed, f, i);
            acc = model_step(acc, pix_data);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] acc, rv, held;
        int nf;
        repeat (3) @(negedge clk);
        rd(A_CTRL, rv); check("R1 ctrl after reset", rv, 32'h0);
        rd(A_SIG, rv);  check("R1 signature after reset", rv, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: one-shot windows of various lengths (R4 R5 R11 R3)
        for (int v = 0; v < 5; v++) begin
            wr(A_CTRL, 32'h400);
            wr(A_CTRL, 32'h100 | 32'(VEC[v][31:24]));
            rd(A_CTRL, rv); check("R3 ctrl readback", rv, 32'h100 | 32'(VEC[v][31:24]));
            acc = '0;
            nf = int'(VEC[v][31:24]);
            for (int f = 0; f < nf; f++) frame(int'(VEC[v][23:16]), int'(VEC[v][15:0]), f, acc);
            rd(A_CTRL, rv); check("R5 status after window", rv, 32'h300 | 32'(VEC[v][31:24]));
            rd(A_SIG, rv);  check("R4 R11 signature of window", rv, acc);
        end

        // R8: one-shot result frozen under further frames
        rd(A_SIG, held);
        acc = '0;
        frame(3, 16'h7777, 0, acc);
        rd(A_SIG, rv);  check("R8 signature frozen", rv, held);
        rd(A_CTRL, rv); check("R8 status kept", rv, 32'h304);

        // R7: clear zeroes status and signature, bit 10 not stored
        wr(A_CTRL, 32'h400);
        rd(A_CTRL, rv); check("R7 ctrl after clear", rv, 32'h0);
        rd(A_SIG, rv);  check("R7 signature after clear", rv, 32'h0);

        // R6: frame count 0 acts as 1
        wr(A_CTRL, 32'h100);
        acc = '0;
        frame(2, 16'h2222, 0, acc);
        rd(A_CTRL, rv); check("R6 status after one frame", rv, 32'h300);
        rd(A_SIG, rv);  check("R6 signature", rv, acc);

        // R9: free-run windows replace each other
        wr(A_CTRL, 32'h400);
        wr(A_CTRL, 32'h8000_0102);
        acc = '0;
        for (int f = 0; f < 2; f++) frame(3, 16'h0055, f, acc);
        rd(A_SIG, rv);  check("R9 first window", rv, acc);
        rd(A_CTRL, rv); check("R9 ctrl", rv, 32'h8000_0302);
        acc = '0;
        for (int f = 0; f < 2; f++) frame(2, 16'h0066, f, acc);
        rd(A_SIG, rv);  check("R9 second window", rv, acc);

        // R11: stray pixels and a lone frame end before the first frame start
        wr(A_CTRL, 32'h400);
        wr(A_CTRL, 32'h101);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; pix_data = 32'hDEAD_0000 + 32'(i);
        end
        @(negedge clk);
        pix_valid = 1'b0; frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        rd(A_CTRL, rv); check("R11 no status before frame start", rv, 32'h101);
        acc = '0;
        frame(4, 16'h1111, 0, acc);
        rd(A_SIG, rv);  check("R11 signature ignores pre-start data", rv, acc);

        // R10: disabled block ignores traffic
        wr(A_CTRL, 32'h400);
        acc = '0;
        frame(3, 16'h3333, 0, acc);
        frame(3, 16'h3334, 1, acc);
        rd(A_CTRL, rv); check("R10 ctrl while off", rv, 32'h0);
        rd(A_SIG, rv);  check("R10 signature while off", rv, 32'h0);

        // R2 R7: undefined bits and addresses read zero
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, rv); check("R2 R7 ctrl undefined bits", rv, 32'h8000_01FF);
        rd(12'h188, rv); check("R2 address above", rv, 32'h0);
        rd(12'h17C, rv); check("R2 address below", rv, 32'h0);
        rd(12'h000, rv); check("R2 address zero", rv, 32'h0);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, rv); check("R3 all-zero write disables", rv, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule